// File: doc/BRIEF.md
# UART Register and Command Controller

This block is the byte-wide, memory-mapped control front end of a serial port. Software reaches it through a simple read/write register bus. It holds two mode registers that share one address and are selected by an advancing pointer. It decodes a packed command byte into receiver, transmitter and housekeeping actions. It reports transmitter and receive-FIFO state in a status register. It keeps an interrupt status and mask pair and drives one level-sensitive interrupt line.

A separate receive FIFO supplies its empty flag, its full flag and its head byte. The controller returns a pop strobe, a flush strobe and the receiver enable. On the transmit side one byte is staged and offered downstream with a valid/ready handshake. Baud generation and serialisation sit outside this block.

The transmit stage is a two-state machine. In `TXS_EMPTY` no byte is held. A buffer write moves it to `TXS_LOADED`. In `TXS_LOADED` the byte is offered while the transmitter is enabled. It returns to `TXS_EMPTY` when the byte is accepted, or when a transmitter-reset command drops it. A buffer write while loaded replaces the byte and stays in `TXS_LOADED`.

Top module: `uart_regctl`

## Requirements
- R1: After reset, status reads 0x08 (transmit empty only), both mode registers, the interrupt status and the interrupt mask read 0, both enables are low, irq is low, and the mode pointer selects the first mode register.
- R2: Only the low 6 address bits are decoded. Offset 0x00 is mode, 0x04 is status, 0x08 is command, 0x0C is data, 0x14 is interrupt status/mask, and 0x18/0x1C return the parameters DIV0_VAL/DIV1_VAL. Every other offset reads 0.
- R3: Reads and writes at offset 0x00 use the current pointer. A write there moves the pointer to the second mode register, where it stays until command field bits 6:4 equal 1.
- R4: Command bits 6:4 = 2 clears the receiver enable, pulses the FIFO flush and so clears receive ready and FIFO full.
- R5: Command bits 6:4 = 3 clears the transmitter enable and sets transmit empty, discarding any held byte.
- R6: Command bits 3:2 (transmitter) and 1:0 (receiver) use 1 = enable, 2 = disable, 3 = no effect. The field in bits 6:4 acts first, then bits 3:2, then bits 1:0.
- R7: A write to 0x0C clears status bit3 (transmit empty). The byte is offered on tx_valid/tx_data while status bit2 (transmit ready, which mirrors the transmitter enable) is set, and held stable until tx_ready. Status bit3 sets on acceptance.
- R8: Status bit0 is FIFO not empty and bit1 is FIFO full. A read of 0x0C returns the FIFO head and pops it. When the FIFO is empty that read returns 0 and does not pop.
- R9: Interrupt status bit0 is transmit ready. Bit1 is FIFO full when bit6 of the first mode register is 1, and FIFO not empty otherwise. Bit2 is set by a brk_evt pulse and cleared by command bits 6:4 = 5.
- R10: irq is high exactly when the interrupt status AND the interrupt mask is nonzero.
- R11: Read data appears on rdata in the cycle after the read strobe and holds otherwise. Writes to 0x04, 0x10 and undecoded offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address, low 6 bits decoded |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rxf_empty | input | 1 | Receive FIFO empty |
| rxf_full | input | 1 | Receive FIFO full |
| rxf_data | input | 8 | Receive FIFO head byte |
| rxf_pop | output | 1 | Pop the FIFO head |
| rxf_flush | output | 1 | Empty the FIFO |
| rx_en | output | 1 | Receiver enable |
| brk_evt | input | 1 | Break-change event pulse |
| tx_valid | output | 1 | Transmit byte offered |
| tx_ready | input | 1 | Downstream accepts the byte |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Level interrupt |

## Verification
The bench goes after the command field ordering. A reset-transmitter or reset-receiver combined with an enable in the same byte must leave the unit enabled; a decoder that applied the fields in the wrong order would leave it disabled. The reserved enable code is also exercised; a design that decoded it as enable or disable would toggle an enable. The pointer's stickiness is checked across a write to the second mode register; a non-sticky pointer would read back the first register. The receive interrupt source is switched between full and ready, the FIFO is read while empty, and a byte is held against a stalled sink. A wrong design would, in turn, raise the interrupt at the wrong fill level, pop an empty FIFO, or lose or repeat the staged byte.

// File: rtl/uart_regctl_pkg.sv
package uart_regctl_pkg;

    localparam int OFS_W = 6;

    localparam logic [OFS_W-1:0] OFS_MODE = 6'h00;
    localparam logic [OFS_W-1:0] OFS_STAT = 6'h04;
    localparam logic [OFS_W-1:0] OFS_CMD  = 6'h08;
    localparam logic [OFS_W-1:0] OFS_DATA = 6'h0C;
    localparam logic [OFS_W-1:0] OFS_INT  = 6'h14;
    localparam logic [OFS_W-1:0] OFS_DIV0 = 6'h18;
    localparam logic [OFS_W-1:0] OFS_DIV1 = 6'h1C;

    // bit 6 of the first mode register selects the receive interrupt source
    localparam int RXSRC_BIT = 6;

    typedef enum logic [2:0] {
        MISC_NOP     = 3'd0,
        MISC_PTR_RST = 3'd1,
        MISC_RX_RST  = 3'd2,
        MISC_TX_RST  = 3'd3,
        MISC_ERR_RST = 3'd4,
        MISC_BRK_CLR = 3'd5,
        MISC_BRK_ON  = 3'd6,
        MISC_BRK_OFF = 3'd7
    } misc_cmd_e;

    typedef enum logic [1:0] {
        EN_KEEP = 2'd0,
        EN_ON   = 2'd1,
        EN_OFF  = 2'd2,
        EN_RSVD = 2'd3
    } en_cmd_e;

    typedef struct packed {
        logic ptr_rst;
        logic rx_rst;
        logic tx_rst;
        logic brk_clr;
    } cmd_act_t;

    typedef enum logic {
        TXS_EMPTY  = 1'b0,
        TXS_LOADED = 1'b1
    } tx_state_e;

endpackage

// File: rtl/uart_cmd_decode.sv
module uart_cmd_decode
    import uart_regctl_pkg::*;
#(
    parameter int CMD_W = 8
) (
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd,
    input  logic             tx_en_q,
    input  logic             rx_en_q,
    output cmd_act_t         act,
    output logic             tx_en_d,
    output logic             rx_en_d
);

    misc_cmd_e misc;
    en_cmd_e   tx_op;
    en_cmd_e   rx_op;
    logic      unused_cmd_hi;

    assign misc          = misc_cmd_e'(cmd[6:4]);
    assign tx_op         = en_cmd_e'(cmd[3:2]);
    assign rx_op         = en_cmd_e'(cmd[1:0]);
    assign unused_cmd_hi = ^cmd[CMD_W-1:7];

    // R4 R5 R6: the misc field acts first, then the transmitter field, then the receiver field
    always_comb begin
        act     = '0;
        tx_en_d = tx_en_q;
        rx_en_d = rx_en_q;
        if (cmd_wr) begin
            unique case (misc)
                MISC_PTR_RST: act.ptr_rst = 1'b1;
                MISC_RX_RST: begin
                    act.rx_rst = 1'b1;
                    rx_en_d    = 1'b0;
                end
                MISC_TX_RST: begin
                    act.tx_rst = 1'b1;
                    tx_en_d    = 1'b0;
                end
                MISC_BRK_CLR: act.brk_clr = 1'b1;
                MISC_NOP, MISC_ERR_RST, MISC_BRK_ON, MISC_BRK_OFF: ;
            endcase
            unique case (tx_op)
                EN_ON:  tx_en_d = 1'b1;
                EN_OFF: tx_en_d = 1'b0;
                EN_KEEP, EN_RSVD: ;
            endcase
            unique case (rx_op)
                EN_ON:  rx_en_d = 1'b1;
                EN_OFF: rx_en_d = 1'b0;
                EN_KEEP, EN_RSVD: ;
            endcase
        end
    end

endmodule

// File: rtl/uart_tx_stage.sv
module uart_tx_stage
    import uart_regctl_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              drop,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_empty
);

    tx_state_e         state_q, state_d;
    logic [DATA_W-1:0] hold_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TXS_EMPTY;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            if (load) hold_q <= load_data;
        end
    end

    // next state: R5 drop, R7 load and accept
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TXS_EMPTY: begin
                if (load) state_d = TXS_LOADED;
            end
            TXS_LOADED: begin
                if (drop)                      state_d = TXS_EMPTY;
                else if (load)                 state_d = TXS_LOADED;
                else if (tx_valid && tx_ready) state_d = TXS_EMPTY;
            end
        endcase
    end

    // outputs
    always_comb begin
        tx_valid = (state_q == TXS_LOADED) && tx_en;
        tx_empty = (state_q == TXS_EMPTY);
        tx_data  = hold_q;
    end

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !load && !drop && tx_en)
        |=> (tx_valid && $stable(tx_data))); // R7

    AST_TX_ACCEPT_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && !load) |=> tx_empty); // R7

    AST_TX_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && !load) |=> (tx_empty && !tx_valid)); // R5

endmodule

// File: rtl/uart_irq_ctl.sv
module uart_irq_ctl #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              brk_evt,
    input  logic              brk_clr,
    input  logic              rx_src_full,
    input  logic              rx_ready,
    input  logic              rx_full,
    input  logic              tx_rdy,
    output logic [DATA_W-1:0] isr,
    output logic              irq
);

    logic [DATA_W-1:0] imr_q;
    logic              brk_q;
    logic              rx_bit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imr_q <= '0;
            brk_q <= 1'b0;
        end else begin
            if (mask_wr) imr_q <= wdata;
            if (brk_evt)      brk_q <= 1'b1;
            else if (brk_clr) brk_q <= 1'b0;
        end
    end

    // R9: the receive source is chosen by the mode bit
    always_comb begin
        rx_bit = rx_src_full ? rx_full : rx_ready;
        isr    = '0;
        isr[0] = tx_rdy;
        isr[1] = rx_bit;
        isr[2] = brk_q;
        irq    = |(isr & imr_q);   // R10
    end

    AST_MASK_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && (wdata == '0)) |=> !irq); // R10

    AST_BRK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_clr && !brk_evt) |=> !isr[2]); // R9

    AST_BRK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        brk_evt |=> isr[2]); // R9

endmodule

// File: rtl/uart_regctl.sv
module uart_regctl
    import uart_regctl_pkg::*;
#(
    parameter int         ADDR_W   = 8,
    parameter int         DATA_W   = 8,
    parameter logic [7:0] DIV0_VAL = 8'hA5,
    parameter logic [7:0] DIV1_VAL = 8'h3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              rxf_empty,
    input  logic              rxf_full,
    input  logic [DATA_W-1:0] rxf_data,
    output logic              rxf_pop,
    output logic              rxf_flush,
    output logic              rx_en,
    input  logic              brk_evt,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [DATA_W-1:0] tx_data,
    output logic              irq
);

    localparam int HI_W = ADDR_W - OFS_W;

    logic [OFS_W-1:0]  ofs;
    logic              unused_addr_hi;
    logic [DATA_W-1:0] mode_a_q, mode_b_q;
    logic              ptr_q;
    logic              tx_en_q, rx_en_q, tx_en_d, rx_en_d;
    logic [DATA_W-1:0] rdata_q, rd_mux;
    logic [DATA_W-1:0] status, isr;
    logic              tx_empty;
    cmd_act_t          act;
    logic              wr_mode, wr_cmd, wr_data, wr_mask, rd_data;

    // R2: decode modulo 64
    assign ofs            = addr[OFS_W-1:0];
    assign unused_addr_hi = ^addr[ADDR_W-1:ADDR_W-HI_W];

    assign wr_mode = wr_en && (ofs == OFS_MODE);
    assign wr_cmd  = wr_en && (ofs == OFS_CMD);
    assign wr_data = wr_en && (ofs == OFS_DATA);
    assign wr_mask = wr_en && (ofs == OFS_INT);
    assign rd_data = rd_en && (ofs == OFS_DATA);

    uart_cmd_decode #(.CMD_W(DATA_W)) u_cmd (
        .cmd_wr (wr_cmd),
        .cmd    (wdata),
        .tx_en_q(tx_en_q),
        .rx_en_q(rx_en_q),
        .act    (act),
        .tx_en_d(tx_en_d),
        .rx_en_d(rx_en_d)
    );

    uart_tx_stage #(.DATA_W(DATA_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_en    (tx_en_q),
        .load     (wr_data),
        .load_data(wdata),
        .drop     (act.tx_rst),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_empty (tx_empty)
    );

    uart_irq_ctl #(.DATA_W(DATA_W)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask_wr    (wr_mask),
        .wdata      (wdata),
        .brk_evt    (brk_evt),
        .brk_clr    (act.brk_clr),
        .rx_src_full(mode_a_q[RXSRC_BIT]),
        .rx_ready   (!rxf_empty),
        .rx_full    (rxf_full),
        .tx_rdy     (tx_en_q),
        .isr        (isr),
        .irq        (irq)
    );

    // R3 mode registers and pointer; R4..R6 enables; R11 registered read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_a_q <= '0;
            mode_b_q <= '0;
            ptr_q    <= 1'b0;
            tx_en_q  <= 1'b0;
            rx_en_q  <= 1'b0;
            rdata_q  <= '0;
        end else begin
            tx_en_q <= tx_en_d;
            rx_en_q <= rx_en_d;
            if (wr_mode) begin
                if (ptr_q) mode_b_q <= wdata;
                else       mode_a_q <= wdata;
                ptr_q <= 1'b1;
            end else if (act.ptr_rst) begin
                ptr_q <= 1'b0;
            end
            if (rd_en) rdata_q <= rd_mux;
        end
    end

    // R7 R8: status layout
    always_comb begin
        status    = '0;
        status[0] = !rxf_empty;
        status[1] = rxf_full;
        status[2] = tx_en_q;
        status[3] = tx_empty;
    end

    always_comb begin
        unique case (ofs)
            OFS_MODE: rd_mux = ptr_q ? mode_b_q : mode_a_q;
            OFS_STAT: rd_mux = status;
            OFS_DATA: rd_mux = rxf_empty ? '0 : rxf_data;
            OFS_INT:  rd_mux = isr;
            OFS_DIV0: rd_mux = DATA_W'(DIV0_VAL);
            OFS_DIV1: rd_mux = DATA_W'(DIV1_VAL);
            default:  rd_mux = '0;
        endcase
    end

    assign rdata     = rdata_q;
    assign rxf_pop   = rd_data && !rxf_empty;
    assign rxf_flush = act.rx_rst;
    assign rx_en     = rx_en_q;

    AST_PTR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mode |=> ptr_q); // R3

    AST_RX_RST_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && (wdata[6:4] == 3'd2) && (wdata[1:0] != 2'd1)) |=> !rx_en); // R4

    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && rxf_empty) |=> (rdata == '0)); // R8

    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        rxf_empty |-> !rxf_pop); // R8

endmodule

// File: tb/uart_regctl_tb_top.sv
module uart_regctl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] addr = '0, wdata = '0;
    logic [7:0] rdata;
    logic       rxf_empty, rxf_full;
    logic [7:0] rxf_data;
    logic       rxf_pop, rxf_flush, rx_en;
    logic       brk_evt = 1'b0;
    logic       tx_valid, tx_ready = 1'b0;
    logic [7:0] tx_data;
    logic       irq;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    uart_regctl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rxf_empty(rxf_empty), .rxf_full(rxf_full),
        .rxf_data(rxf_data), .rxf_pop(rxf_pop), .rxf_flush(rxf_flush), .rx_en(rx_en),
        .brk_evt(brk_evt), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .irq(irq)
    );

    // receive FIFO model, depth 4
    logic [7:0] fq [4];
    int         fcnt = 0, pop_cnt = 0, acc_cnt = 0;
    logic       push_req = 1'b0;
    logic [7:0] push_byte = '0, last_tx = '0;

    assign rxf_empty = (fcnt == 0);
    assign rxf_full  = (fcnt == 4);
    assign rxf_data  = fq[0];

    always @(posedge clk) begin
        if (rxf_flush) fcnt <= 0;
        else if (rxf_pop) begin
            for (int i = 0; i < 3; i++) fq[i] <= fq[i+1];
            fcnt    <= fcnt - 1;
            pop_cnt <= pop_cnt + 1;
        end else if (push_req && fcnt < 4) begin
            fq[fcnt] <= push_byte;
            fcnt     <= fcnt + 1;
        end
        if (tx_valid && tx_ready) begin
            acc_cnt <= acc_cnt + 1;
            last_tx <= tx_data;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; d = rdata;
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk); push_req = 1'b1; push_byte = b;
        @(negedge clk); push_req = 1'b0;
    endtask

    // stimulus table: op 0 = write, 1 = read and compare
    typedef struct packed {
        logic       op;
        logic [7:0] a;
        logic [7:0] d;
        logic [7:0] exp;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 8'h00, 8'h00, 8'h00, 8'd1},  // R1 mode A
        '{1'b1, 8'h04, 8'h00, 8'h08, 8'd1},  // R1 status
        '{1'b1, 8'h14, 8'h00, 8'h00, 8'd1},  // R1 isr
        '{1'b0, 8'h00, 8'h40, 8'h00, 8'd3},  // write mode A
        '{1'b1, 8'h00, 8'h00, 8'h00, 8'd3},  // R3 now mode B
        '{1'b0, 8'h00, 8'h13, 8'h00, 8'd3},  // write mode B
        '{1'b1, 8'h00, 8'h00, 8'h13, 8'd3},  // R3 sticky
        '{1'b1, 8'h80, 8'h00, 8'h13, 8'd2},  // R2 alias
        '{1'b0, 8'h08, 8'h10, 8'h00, 8'd3},  // pointer reset
        '{1'b1, 8'h00, 8'h00, 8'h40, 8'd3},  // R3 back at A
        '{1'b1, 8'h18, 8'h00, 8'hA5, 8'd2},  // R2 divisor 0
        '{1'b1, 8'h1C, 8'h00, 8'h3C, 8'd2},  // R2 divisor 1
        '{1'b1, 8'h10, 8'h00, 8'h00, 8'd2},  // R2 aux
        '{1'b1, 8'h24, 8'h00, 8'h00, 8'd2},  // R2 undecoded
        '{1'b0, 8'h04, 8'hFF, 8'h00, 8'd11}, // write status
        '{1'b1, 8'h04, 8'h00, 8'h08, 8'd11}, // R11 ignored
        '{1'b0, 8'h08, 8'h04, 8'h00, 8'd6},  // tx enable
        '{1'b1, 8'h04, 8'h00, 8'h0C, 8'd6},  // R6
        '{1'b1, 8'h14, 8'h00, 8'h01, 8'd9},  // R9 bit0
        '{1'b0, 8'h0C, 8'h5A, 8'h00, 8'd7},  // buffer, sink stalled
        '{1'b1, 8'h04, 8'h00, 8'h04, 8'd7},  // R7 empty cleared
        '{1'b0, 8'h08, 8'h3C, 8'h00, 8'd5},  // tx reset + reserved
        '{1'b1, 8'h04, 8'h00, 8'h08, 8'd5},  // R5
        '{1'b0, 8'h08, 8'h34, 8'h00, 8'd6},  // tx reset then enable
        '{1'b1, 8'h04, 8'h00, 8'h0C, 8'd6},  // R6 order
        '{1'b0, 8'h08, 8'h0C, 8'h00, 8'd6},  // reserved
        '{1'b1, 8'h04, 8'h00, 8'h0C, 8'd6},  // R6 no effect
        '{1'b0, 8'h08, 8'h08, 8'h00, 8'd6},  // disable
        '{1'b1, 8'h04, 8'h00, 8'h08, 8'd6},  // R6
        '{1'b0, 8'h10, 8'hFF, 8'h00, 8'd11}, // aux write
        '{1'b1, 8'h10, 8'h00, 8'h00, 8'd11}  // R11
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        int         p0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 irq", {7'd0, irq}, 8'h00);
        chk("R1 rx_en", {7'd0, rx_en}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].op) begin
                bus_rd(VEC[i].a, r);
                chk($sformatf("R%0d vec%0d", VEC[i].req, i), r, VEC[i].exp);
            end else begin
                bus_wr(VEC[i].a, VEC[i].d);
            end
        end

        // R5: dropped byte is not offered; R7 handshake
        bus_wr(8'h08, 8'h04);
        chk("R5 dropped", {7'd0, tx_valid}, 8'h00);
        bus_wr(8'h0C, 8'hC3);
        chk("R7 valid", {7'd0, tx_valid}, 8'h01);
        repeat (3) @(negedge clk);
        chk("R7 held data", tx_data, 8'hC3);
        bus_rd(8'h04, r);
        chk("R7 not empty", r, 8'h04);
        @(negedge clk); tx_ready = 1'b1;
        @(negedge clk); tx_ready = 1'b0;
        chk("R7 accepted", {7'd0, tx_valid}, 8'h00);
        chk("R7 one byte", acc_cnt[7:0], 8'h01);
        chk("R7 byte", last_tx, 8'hC3);
        bus_rd(8'h04, r);
        chk("R7 empty again", r, 8'h0C);

        // R10
        bus_wr(8'h14, 8'h01);
        chk("R10 irq on", {7'd0, irq}, 8'h01);
        bus_wr(8'h14, 8'h00);
        chk("R10 irq off", {7'd0, irq}, 8'h00);

        // R8 R9 receive, mode A bit6 = 1 selects full
        bus_wr(8'h08, 8'h01);
        chk("R6 rx on", {7'd0, rx_en}, 8'h01);
        push(8'h11); push(8'h22); push(8'h33);
        bus_rd(8'h04, r);  chk("R8 ready", r, 8'h0D);
        bus_rd(8'h14, r);  chk("R9 full src", r, 8'h01);
        push(8'h44);
        bus_rd(8'h04, r);  chk("R8 full", r, 8'h0F);
        bus_rd(8'h14, r);  chk("R9 full set", r, 8'h03);
        bus_wr(8'h14, 8'h02);
        chk("R10 rx irq", {7'd0, irq}, 8'h01);
        bus_rd(8'h0C, r);  chk("R8 head", r, 8'h11);
        bus_rd(8'h14, r);  chk("R9 not full", r, 8'h01);
        chk("R10 rx irq off", {7'd0, irq}, 8'h00);
        bus_wr(8'h08, 8'h10);
        bus_wr(8'h00, 8'h00);
        bus_rd(8'h14, r);  chk("R9 ready src", r, 8'h03);

        // R4 with ordering
        bus_wr(8'h08, 8'h21);
        chk("R4 R6 rx kept on", {7'd0, rx_en}, 8'h01);
        bus_rd(8'h04, r);  chk("R4 flushed", r, 8'h0C);
        bus_wr(8'h08, 8'h20);
        chk("R4 rx off", {7'd0, rx_en}, 8'h00);

        // R8 empty read
        p0 = pop_cnt;
        bus_rd(8'h0C, r);  chk("R8 empty read", r, 8'h00);
        chk("R8 no pop", 8'(pop_cnt - p0), 8'h00);

        // R9 break
        @(negedge clk); brk_evt = 1'b1;
        @(negedge clk); brk_evt = 1'b0;
        bus_rd(8'h14, r);  chk("R9 brk set", r, 8'h05);
        bus_wr(8'h08, 8'h50);
        bus_rd(8'h14, r);  chk("R9 brk clr", r, 8'h01);

        // R11 latency
        bus_rd(8'h04, r);
        @(negedge clk); rd_en = 1'b1; addr = 8'h18;
        #1 chk("R11 not early", rdata, 8'h0C);
        @(negedge clk); rd_en = 1'b0;
        chk("R11 next cycle", rdata, 8'hA5);
        repeat (2) @(negedge clk);
        chk("R11 hold", rdata, 8'hA5);

        // R1 reset mid-run
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        chk("R1 irq after", {7'd0, irq}, 8'h00);
        bus_rd(8'h04, r);  chk("R1 status after", r, 8'h08);
        bus_rd(8'h14, r);  chk("R1 isr after", r, 8'h00);
        bus_wr(8'h00, 8'h77);
        bus_wr(8'h08, 8'h10);
        bus_rd(8'h00, r);  chk("R1 R3 pointer at A", r, 8'h77);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule